// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles. It produces a quotient and a remainder. It uses restoring division: it trial-subtracts a shifting divisor from a partial remainder and records one quotient bit per step. Operands can be unsigned or two's-complement signed, chosen per operation. Signed division first takes the magnitudes of the operands, divides them, and then corrects the signs of the results.

A client pulses `start_i` while the unit is idle, with the operands and the mode on the same cycle. `busy_o` stays high while the iteration runs. `done_o` pulses once when the results are ready. The results then hold until the next accepted start. Division by zero and the one signed overflow case do not raise errors. Each returns a fixed result, so software can treat them as ordinary values.

Top module: `seq_divider`

## Requirements
- R1: While reset is active and after it, with no start, busy_o and done_o are 0 and quotient_o and remainder_o are 0.
- R2: A start accepted at a rising edge sets busy_o after that edge. After exactly N+1 further edges, done_o is 1 and busy_o is 0. done_o stays high for one cycle only.
- R3: While busy_o is 1, start_i, dividend_i, divisor_i and signed_i are ignored. The running operation keeps its timing and its result.
- R4: With signed_i = 0 and a nonzero divisor, quotient_o is the unsigned floor of dividend/divisor, and remainder_o = dividend - quotient*divisor, which is less than the divisor.
- R5: With signed_i = 1 and a nonzero divisor, the quotient is rounded toward zero. It is negative when the operand signs differ. The remainder carries the sign of the dividend, and its magnitude is less than the divisor's.
- R6: If the divisor is zero, quotient_o is all ones and remainder_o equals the dividend, in both modes.
- R7: In signed mode, the most negative value divided by -1 gives a quotient equal to the dividend and a remainder of 0.
- R8: After done_o, quotient_o and remainder_o hold their values until the next accepted start, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| dividend_i | input | N | Dividend |
| divisor_i | input | N | Divisor |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| quotient_o | output | N | Quotient |
| remainder_o | output | N | Remainder |

## Verification
The bench raises start_i at a falling edge so that the next rising edge accepts it. At the falling edge after that, busy_o must be high. The bench then counts falling edges until done_o appears and requires exactly N+1 of them. Quotient and remainder are compared at the falling edge where done_o is first seen. That is the earliest point where the final step's registers are settled. One cycle later done_o must be low again. Several idle cycles later, with the inputs changed, both results must be unchanged. For the ignored-start case the bench toggles the inputs mid-run and still expects the first operation's result and its cycle count.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic neg_quo;   // flip quotient sign
    logic neg_rem;   // flip remainder sign
    logic zero_div;  // divisor was zero
  } div_fix_t;
endpackage

// File: rtl/div_sign_prep.sv
module div_sign_prep
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         signed_i,
  output logic [W-1:0] dvd_mag_o,
  output logic [W-1:0] dvs_mag_o,
  output div_fix_t     fix_o
);
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg   = signed_i & dividend_i[W-1];
    dvs_neg   = signed_i & divisor_i[W-1];
    dvd_mag_o = dvd_neg ? (~dividend_i + 1'b1) : dividend_i;
    dvs_mag_o = dvs_neg ? (~divisor_i + 1'b1) : divisor_i;
    fix_o.neg_quo  = dvd_neg ^ dvs_neg;
    fix_o.neg_rem  = dvd_neg;
    fix_o.zero_div = (divisor_i == '0);
  end
endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_mag_o,
  output logic [W-1:0] rem_mag_o
);
  localparam int RW = 2 * W;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LastStep = CW'(W);

  logic [RW-1:0] rem_q, dvs_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] step_q;
  logic          busy_q, done_q;
  logic [RW:0]   trial;
  logic          trial_neg;

  // trial subtract; a negative result is discarded (restore)
  always_comb begin
    trial     = {1'b0, rem_q} - {1'b0, dvs_q};
    trial_neg = trial[RW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= {{W{1'b0}}, dvd_mag_i};
      dvs_q  <= {dvs_mag_i, {W{1'b0}}};
      quo_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (!trial_neg) rem_q <= trial[RW-1:0];
      quo_q <= {quo_q[W-2:0], ~trial_neg};
      dvs_q <= dvs_q >> 1;
      if (step_q == LastStep) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign quo_mag_o = quo_q;
  assign rem_mag_o = rem_q[W-1:0];
endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] quo_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  div_fix_t     fix_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  always_comb begin
    if (fix_i.zero_div)     quotient_o = '1;
    else if (fix_i.neg_quo) quotient_o = ~quo_mag_i + 1'b1;
    else                    quotient_o = quo_mag_i;
    remainder_o = fix_i.neg_rem ? (~rem_mag_i + 1'b1) : rem_mag_i;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  input  logic         signed_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  logic [W-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
  div_fix_t     fix_in, fix_q;
  logic         accept, core_busy;

  assign accept = start_i & ~core_busy;

  div_sign_prep #(.W(W)) u_prep (
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .signed_i  (signed_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .fix_o     (fix_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fix_q <= '0;
    else if (accept) fix_q <= fix_in;
  end

  div_restore_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .dvd_mag_i(dvd_mag),
    .dvs_mag_i(dvs_mag),
    .busy_o   (core_busy),
    .done_o   (done_o),
    .quo_mag_o(quo_mag),
    .rem_mag_o(rem_mag)
  );

  div_sign_fix #(.W(W)) u_fix (
    .quo_mag_i  (quo_mag),
    .rem_mag_i  (rem_mag),
    .fix_i      (fix_q),
    .quotient_o (quotient_o),
    .remainder_o(remainder_o)
  );

  assign busy_o = core_busy;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         signed_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o
);
  localparam int CW = $clog2(W + 3);

  logic [W-1:0]  op_a, op_b;
  logic          op_s;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a <= '0; op_b <= '0; op_s <= 1'b0; run_cnt <= '0;
    end else if (start_i && !busy_o) begin
      op_a <= dividend_i; op_b <= divisor_i; op_s <= signed_i; run_cnt <= '0;
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r1_idle_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o && !done_o);

  a_r2_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_step_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_cnt == CW'(W + 1));

  a_r3_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r3_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);

  a_r4_unsigned_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !op_s && op_b != '0 |->
      ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, op_b} + {{W{1'b0}}, remainder_o})
        == {{W{1'b0}}, op_a} && remainder_o < op_b);

  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_b == '0 |-> quotient_o == '1 && remainder_o == op_a);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(quotient_o) && $stable(remainder_o));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (.*);

// File: tb/seq_divider_test.sv
module seq_divider_test;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         signed_i = 1'b0;
  logic         busy_o, done_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  seq_divider #(.W(W)) uut (.*);

  function automatic logic [W-1:0] exp_q(logic [W-1:0] a, logic [W-1:0] b, logic s);
    longint sa, sb;
    if (b == '0) return '1;
    if (!s) return a / b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    return W'(sa / sb);
  endfunction

  function automatic logic [W-1:0] exp_r(logic [W-1:0] a, logic [W-1:0] b, logic s);
    longint sa, sb;
    if (b == '0) return a;
    if (!s) return a % b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    return W'(sa % sb);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // one operation; optional disturbance of inputs while busy
  task automatic run_op(string req, logic [W-1:0] a, logic [W-1:0] b, logic s, bit poke);
    int cnt;
    @(negedge clk_i);
    dividend_i = a; divisor_i = b; signed_i = s; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({req, " R2 busy"}, W'(busy_o), W'(1));
    cnt = 0;
    do begin
      if (poke && cnt < 5) begin
        start_i = 1'b1; dividend_i = ~a; divisor_i = b + 3; signed_i = ~s;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
      cnt++;
    end while (!done_o && cnt < 200);
    start_i = 1'b0;
    check({req, " R2 cycles"}, W'(cnt), W'(W + 1));
    check({req, " R2 busy low"}, W'(busy_o), W'(0));
    check({req, " quotient"}, quotient_o, exp_q(a, b, s));
    check({req, " remainder"}, remainder_o, exp_r(a, b, s));
    @(negedge clk_i);
    check({req, " R2 done pulse"}, W'(done_o), W'(0));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        summary();
      end
    end
  end

  initial begin
    logic [W-1:0] hq, hr;
    void'($urandom(32'd4711));
    #1;
    check("R1 busy in reset", W'(busy_o), W'(0));
    check("R1 done in reset", W'(done_o), W'(0));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 busy", W'(busy_o), W'(0));
    check("R1 done", W'(done_o), W'(0));
    check("R1 quotient", quotient_o, '0);
    check("R1 remainder", remainder_o, '0);

    run_op("R4 7/2", 32'd7, 32'd2, 1'b0, 1'b0);
    run_op("R4 max/1", 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
    run_op("R4 small/big", 32'd5, 32'hFFFF_FFF0, 1'b0, 1'b0);
    run_op("R4 equal", 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0);
    run_op("R4 max/max-1", 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0);
    run_op("R5 -7/2", -32'sd7, 32'd2, 1'b1, 1'b0);
    run_op("R5 7/-2", 32'd7, -32'sd2, 1'b1, 1'b0);
    run_op("R5 -7/-2", -32'sd7, -32'sd2, 1'b1, 1'b0);
    run_op("R5 min/1", 32'h8000_0000, 32'd1, 1'b1, 1'b0);
    run_op("R5 min/2", 32'h8000_0000, 32'd2, 1'b1, 1'b0);
    run_op("R6 unsigned /0", 32'hDEAD_BEEF, 32'd0, 1'b0, 1'b0);
    run_op("R6 signed neg /0", -32'sd9, 32'd0, 1'b1, 1'b0);
    run_op("R6 signed pos /0", 32'd9, 32'd0, 1'b1, 1'b0);
    run_op("R7 min/-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op("R3 poke unsigned", 32'd1000, 32'd7, 1'b0, 1'b1);
    run_op("R3 poke signed", -32'sd1000, 32'd7, 1'b1, 1'b1);

    // R8: results hold with inputs moving but no start
    hq = quotient_o; hr = remainder_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      dividend_i = $urandom; divisor_i = $urandom; signed_i = ~signed_i;
    end
    check("R8 quotient hold", quotient_o, hq);
    check("R8 remainder hold", remainder_o, hr);
    check("R8 idle busy", W'(busy_o), W'(0));

    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      logic s;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b >> ($urandom % 28);
      s = i[0];
      run_op(s ? "R5 random" : "R4 random", a, b, s, 1'b0);
    end
    summary();
  end
endmodule